// File: doc/BRIEF.md
# Memory/I-O Byte Mover with Edge-Triggered Requests

This block is one DMA channel that copies single bytes between a memory address range and one fixed I/O port. Software, or a neighbouring controller, loads a two-bit mode, a 20-bit memory pointer, a 16-bit port address and a 16-bit byte count with a one-cycle load strobe. The channel then waits for a rising edge on its request input. Each edge moves exactly one byte: a read cycle from the source, then a write cycle to the destination. Every bus cycle holds its strobe for two clocks, a strobe clock followed by one wait clock.

The high mode bit selects the direction, and the low mode bit selects whether the memory pointer steps up or down. The port address never changes. Requests are detected on their rising edge and not on their level, because a peripheral on a one-wait-state port cannot drop its request fast enough. A request that rises while a byte is in flight is held and served as soon as that byte is written. When the count runs out, the channel turns itself off and pulses a done output. The bus interface has fixed timing and no handshake, and all pins are plain control and data signals.

Top module: `mio_dma_channel`

## Requirements
- R1: After reset, `chan_en` is 0, `cur_mode` is 2'b00, `xfer_done` is 0, and `bus_rd` and `bus_wr` are both 0.
- R2: Modes 2'b00 and 2'b01 read from memory (`bus_io`=0 at the memory pointer) and write to the port (`bus_io`=1). The memory pointer steps +1 after each byte in mode 2'b00 and -1 after each byte in mode 2'b01.
- R3: Modes 2'b10 and 2'b11 read from the port (`bus_io`=1) and write to memory (`bus_io`=0). The pointer steps +1 after each byte in mode 2'b10 and -1 after each byte in mode 2'b11.
- R4: Every port-side cycle carries the loaded port address, zero-extended on `bus_addr`. This address never changes between bytes.
- R5: Each byte consists of exactly two clocks of `bus_rd`, then exactly two clocks of `bus_wr`. The strobes never overlap. `bus_wdata` equals the `bus_rdata` value sampled in the second read clock, and it holds steady while `bus_wr` is high.
- R6: Requests are edge-sensed. If `req_in` rises before clock edge 1, `bus_rd` goes high after clock edge 4. If `req_in` is held high, only one byte moves.
- R7: A rising edge of `req_in` during a byte transfer is latched. Exactly one further byte is moved after the current one finishes.
- R8: The count drops by one per byte. After the last byte, `chan_en` falls and `xfer_done` is high for exactly one clock, in the same clock that `chan_en` first reads 0.
- R9: The memory pointer wraps modulo 2^20: 20'hFFFFF +1 gives 0, and 0 -1 gives 20'hFFFFF.
- R10: While `chan_en` is 0, request edges are ignored and no strobe is issued.
- R11: `cfg_load` is ignored while a byte is in flight. A load with a count of 0 stores the mode but leaves `chan_en` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_load | input | 1 | One-clock strobe that loads the four settings below |
| cfg_mode | input | 2 | Direction (bit 1) and pointer step sign (bit 0) |
| cfg_mem_addr | input | 20 | Starting memory pointer |
| cfg_io_addr | input | 16 | Fixed port address |
| cfg_count | input | 16 | Number of bytes to move |
| req_in | input | 1 | Asynchronous transfer request, rising-edge active |
| bus_addr | output | 20 | Address of the current bus cycle |
| bus_io | output | 1 | 1 = port space, 0 = memory space |
| bus_rd | output | 1 | Read strobe |
| bus_wr | output | 1 | Write strobe |
| bus_wdata | output | 8 | Write data |
| bus_rdata | input | 8 | Read data, sampled in the second read clock |
| chan_en | output | 1 | Channel armed |
| cur_mode | output | 2 | Currently stored mode |
| xfer_done | output | 1 | One-clock pulse at terminal count |

## Verification
A wrong step sign or a missed wrap shows up on `bus_addr` in the memory cycle of the very next byte, so it is visible within one transfer. A corrupted count surfaces only at terminal count, as a `xfer_done` pulse and a `chan_en` fall that come one or more bytes early or late. For this reason the tests count bytes up to the done pulse. A broken edge latch shows up either as a missing second byte after an edge that arrives mid-transfer, or as extra bytes while the request line is held high, within about ten clocks of the edge.

// File: rtl/mio_dma_pkg.sv
package mio_dma_pkg;

  typedef enum logic [1:0] {
    MODE_M2IO_UP   = 2'b00,
    MODE_M2IO_DOWN = 2'b01,
    MODE_IO2M_UP   = 2'b10,
    MODE_IO2M_DOWN = 2'b11
  } xfer_mode_e;

  typedef enum logic [2:0] {
    ST_IDLE   = 3'd0,
    ST_RD_STB = 3'd1,
    ST_RD_WT  = 3'd2,
    ST_WR_STB = 3'd3,
    ST_WR_WT  = 3'd4
  } seq_state_e;

  // source of the read cycle is the port when the direction bit is set
  function automatic logic src_is_port(input xfer_mode_e m);
    return m[1];
  endfunction

  function automatic logic step_down(input xfer_mode_e m);
    return m[0];
  endfunction

endpackage

// File: rtl/mio_req_edge.sv
module mio_req_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic req_async,
  output logic req_rise
);
  logic [STAGES-1:0] chain;
  logic              last_q;

  for (genvar i = 0; i < STAGES; i++) begin : g_sync
    if (i == 0) begin : g_first
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[0] <= 1'b0;
        else        chain[0] <= req_async;
      end
    end else begin : g_next
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) chain[i] <= 1'b0;
        else        chain[i] <= chain[i-1];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) last_q <= 1'b0;
    else        last_q <= chain[STAGES-1];
  end

  assign req_rise = chain[STAGES-1] & ~last_q;
endmodule

// File: rtl/mio_addr_gen.sv
module mio_addr_gen
  import mio_dma_pkg::*;
#(
  parameter int MEM_AW = 20,
  parameter int IO_AW  = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load_ok,
  input  logic [1:0]        cfg_mode,
  input  logic [MEM_AW-1:0] cfg_mem_addr,
  input  logic [IO_AW-1:0]  cfg_io_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              step,
  output xfer_mode_e        mode,
  output logic [MEM_AW-1:0] mem_ptr,
  output logic [IO_AW-1:0]  io_ptr,
  output logic              en,
  output logic              done
);
  logic [CNT_W-1:0] remain;
  logic             last_byte;

  assign last_byte = (remain == CNT_W'(1));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode    <= MODE_M2IO_UP;
      mem_ptr <= '0;
      io_ptr  <= '0;
      remain  <= '0;
      en      <= 1'b0;
      done    <= 1'b0;
    end else begin
      done <= 1'b0;
      if (load_ok) begin
        mode    <= xfer_mode_e'(cfg_mode);
        mem_ptr <= cfg_mem_addr;
        io_ptr  <= cfg_io_addr;
        remain  <= cfg_count;
        en      <= (cfg_count != '0);
      end else if (step) begin
        // width of mem_ptr makes the step wrap modulo 2^MEM_AW
        if (step_down(mode)) mem_ptr <= mem_ptr - 1'b1;
        else                 mem_ptr <= mem_ptr + 1'b1;
        remain <= remain - 1'b1;
        if (last_byte) begin
          en   <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/mio_bus_seq.sv
module mio_bus_seq
  import mio_dma_pkg::*;
#(
  parameter int MEM_AW = 20,
  parameter int DW     = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_rise,
  input  logic              en,
  input  logic              load_ok,
  input  logic              load_req,
  input  xfer_mode_e        mode,
  input  logic [MEM_AW-1:0] mem_ptr,
  input  logic [MEM_AW-1:0] port_addr,
  input  logic [DW-1:0]     rdata,
  output logic [MEM_AW-1:0] addr,
  output logic              is_io,
  output logic              rd,
  output logic              wr,
  output logic [DW-1:0]     wdata,
  output logic              busy,
  output logic              step
);
  seq_state_e     state, state_nxt;
  logic           pend, start;
  logic [DW-1:0]  hold_q;
  logic           rd_phase, wr_phase;

  assign busy  = (state != ST_IDLE);
  assign start = (state == ST_IDLE) && pend && en && !load_req;
  assign step  = (state == ST_WR_WT);

  always_comb begin
    state_nxt = state;
    unique case (state)
      ST_IDLE:   if (start) state_nxt = ST_RD_STB;
      ST_RD_STB: state_nxt = ST_RD_WT;
      ST_RD_WT:  state_nxt = ST_WR_STB;
      ST_WR_STB: state_nxt = ST_WR_WT;
      ST_WR_WT:  state_nxt = ST_IDLE;
      default:   state_nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= state_nxt;
  end

  // one outstanding request; a new edge wins over consumption
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 pend <= 1'b0;
    else if (load_ok || !en)    pend <= 1'b0;
    else if (req_rise)          pend <= 1'b1;
    else if (start)             pend <= 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                 hold_q <= '0;
    else if (state == ST_RD_WT) hold_q <= rdata;
  end

  assign rd_phase = (state == ST_RD_STB) || (state == ST_RD_WT);
  assign wr_phase = (state == ST_WR_STB) || (state == ST_WR_WT);

  always_comb begin
    rd    = rd_phase;
    wr    = wr_phase;
    wdata = wr_phase ? hold_q : '0;
    is_io = 1'b0;
    addr  = '0;
    if (rd_phase) begin
      is_io = src_is_port(mode);
      addr  = src_is_port(mode) ? port_addr : mem_ptr;
    end else if (wr_phase) begin
      is_io = !src_is_port(mode);
      addr  = src_is_port(mode) ? mem_ptr : port_addr;
    end
  end
endmodule

// File: rtl/mio_dma_channel.sv
module mio_dma_channel
  import mio_dma_pkg::*;
#(
  parameter int MEM_AW      = 20,
  parameter int IO_AW       = 16,
  parameter int CNT_W       = 16,
  parameter int DW          = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_load,
  input  logic [1:0]        cfg_mode,
  input  logic [MEM_AW-1:0] cfg_mem_addr,
  input  logic [IO_AW-1:0]  cfg_io_addr,
  input  logic [CNT_W-1:0]  cfg_count,
  input  logic              req_in,
  output logic [MEM_AW-1:0] bus_addr,
  output logic              bus_io,
  output logic              bus_rd,
  output logic              bus_wr,
  output logic [DW-1:0]     bus_wdata,
  input  logic [DW-1:0]     bus_rdata,
  output logic              chan_en,
  output logic [1:0]        cur_mode,
  output logic              xfer_done
);
  localparam int PAD_W = MEM_AW - IO_AW;

  logic              req_rise, busy, step, load_ok;
  xfer_mode_e        mode;
  logic [MEM_AW-1:0] mem_ptr, port_ext;
  logic [IO_AW-1:0]  io_ptr;

  assign load_ok  = cfg_load && !busy;
  assign port_ext = {{PAD_W{1'b0}}, io_ptr};
  assign cur_mode = mode;

  mio_req_edge #(.STAGES(SYNC_STAGES)) u_edge (
    .clk(clk), .rst_n(rst_n), .req_async(req_in), .req_rise(req_rise)
  );

  mio_addr_gen #(.MEM_AW(MEM_AW), .IO_AW(IO_AW), .CNT_W(CNT_W)) u_addr (
    .clk(clk), .rst_n(rst_n), .load_ok(load_ok), .cfg_mode(cfg_mode),
    .cfg_mem_addr(cfg_mem_addr), .cfg_io_addr(cfg_io_addr),
    .cfg_count(cfg_count), .step(step), .mode(mode), .mem_ptr(mem_ptr),
    .io_ptr(io_ptr), .en(chan_en), .done(xfer_done)
  );

  mio_bus_seq #(.MEM_AW(MEM_AW), .DW(DW)) u_seq (
    .clk(clk), .rst_n(rst_n), .req_rise(req_rise), .en(chan_en),
    .load_ok(load_ok), .load_req(cfg_load), .mode(mode), .mem_ptr(mem_ptr),
    .port_addr(port_ext), .rdata(bus_rdata), .addr(bus_addr), .is_io(bus_io),
    .rd(bus_rd), .wr(bus_wr), .wdata(bus_wdata), .busy(busy), .step(step)
  );
endmodule

// File: rtl/mio_dma_chk.sv
module mio_dma_chk #(
  parameter int MEM_AW = 20,
  parameter int DW     = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic [MEM_AW-1:0] bus_addr,
  input logic              bus_io,
  input logic              bus_rd,
  input logic              bus_wr,
  input logic [DW-1:0]     bus_wdata,
  input logic              chan_en,
  input logic              xfer_done
);
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_wr));

  assert_rd_two_clocks_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_rd) |=> bus_rd);

  assert_wr_after_rd_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(bus_rd) |-> bus_wr);

  assert_wdata_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(bus_wr) |=> bus_wr && $stable(bus_wdata));

  assert_port_addr_steady_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd || bus_wr) && bus_io && $past((bus_rd || bus_wr) && bus_io)
      |-> $stable(bus_addr));

  assert_done_one_clock_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |=> !xfer_done);

  assert_done_with_disable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    xfer_done |-> !chan_en && $past(chan_en));

  assert_quiet_when_off_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !chan_en |-> !bus_rd && !bus_wr);
endmodule

bind mio_dma_channel mio_dma_chk #(.MEM_AW(MEM_AW), .DW(DW)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_io(bus_io),
  .bus_rd(bus_rd), .bus_wr(bus_wr), .bus_wdata(bus_wdata),
  .chan_en(chan_en), .xfer_done(xfer_done)
);

// File: tb/sim_mio_dma_channel.sv
`timescale 1ns/100ps
module sim_mio_dma_channel;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_load = 1'b0;
  logic [1:0]  cfg_mode = '0;
  logic [19:0] cfg_mem_addr = '0;
  logic [15:0] cfg_io_addr = '0;
  logic [15:0] cfg_count = '0;
  logic        req_in = 1'b0;
  logic [19:0] bus_addr;
  logic        bus_io, bus_rd, bus_wr, chan_en, xfer_done;
  logic [7:0]  bus_wdata, bus_rdata;
  logic [1:0]  cur_mode;
  logic [7:0]  io_src = 8'h00;

  int vectors = 0;
  int fails = 0;
  logic [19:0] rd_a [0:15];
  logic        rd_i [0:15];
  logic [19:0] wr_a [0:15];
  logic        wr_i [0:15];
  logic [7:0]  wr_d [0:15];
  int n_rd = 0, n_wr = 0, n_done = 0;
  logic rd_prev = 1'b0, wr_prev = 1'b0;

  always #2.5 clk = ~clk;

  assign bus_rdata = bus_io ? io_src : (bus_addr[7:0] ^ 8'h5A);

  mio_dma_channel u0 (
    .clk(clk), .rst_n(rst_n), .cfg_load(cfg_load), .cfg_mode(cfg_mode),
    .cfg_mem_addr(cfg_mem_addr), .cfg_io_addr(cfg_io_addr),
    .cfg_count(cfg_count), .req_in(req_in), .bus_addr(bus_addr),
    .bus_io(bus_io), .bus_rd(bus_rd), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .chan_en(chan_en),
    .cur_mode(cur_mode), .xfer_done(xfer_done)
  );

  always @(negedge clk) begin
    if (bus_rd && !rd_prev && n_rd < 16) begin
      rd_a[n_rd] = bus_addr; rd_i[n_rd] = bus_io; n_rd++;
    end
    if (bus_wr && !wr_prev && n_wr < 16) begin
      wr_a[n_wr] = bus_addr; wr_i[n_wr] = bus_io; wr_d[n_wr] = bus_wdata; n_wr++;
    end
    if (xfer_done) n_done++;
    rd_prev = bus_rd;
    wr_prev = bus_wr;
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic clear_log();
    n_rd = 0; n_wr = 0; n_done = 0;
  endtask

  task automatic load(input logic [1:0] m, input logic [19:0] ma,
                      input logic [15:0] ia, input logic [15:0] c);
    @(negedge clk);
    cfg_mode = m; cfg_mem_addr = ma; cfg_io_addr = ia; cfg_count = c;
    cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
  endtask

  task automatic pulse_req();
    @(negedge clk); req_in = 1'b1;
    repeat (3) @(negedge clk);
    req_in = 1'b0;
    repeat (12) @(negedge clk);
  endtask

  task automatic t_reset();
    chk("R1 chan_en", chan_en, 0);
    chk("R1 cur_mode", cur_mode, 0);
    chk("R1 done", xfer_done, 0);
    chk("R1 strobes", {bus_rd, bus_wr}, 0);
  endtask

  task automatic t_mode_up_out();
    clear_log();
    load(2'b00, 20'h00100, 16'h0040, 16'd3);
    chk("R11 armed", chan_en, 1);
    req_in = 1'b1;
    repeat (3) @(negedge clk);
    chk("R6 no rd before edge 4", bus_rd, 0);
    @(negedge clk);
    chk("R6 rd after edge 4", bus_rd, 1);
    req_in = 1'b0;
    repeat (12) @(negedge clk);
    chk("R8 not done after 1", n_done, 0);
    pulse_req();
    pulse_req();
    chk("R2 writes", n_wr, 3);
    for (int k = 0; k < 3; k++) begin
      chk("R2 rd addr", rd_a[k], 20'h00100 + k);
      chk("R2 rd mem", rd_i[k], 0);
      chk("R4 wr port", wr_a[k], 20'h00040);
      chk("R2 wr io", wr_i[k], 1);
      chk("R5 wdata", wr_d[k], 8'(k) ^ 8'h5A);
    end
    chk("R8 one done", n_done, 1);
    chk("R8 disabled", chan_en, 0);
  endtask

  task automatic t_mode_down_out();
    clear_log();
    load(2'b01, 20'h00000, 16'h0012, 16'd2);
    pulse_req();
    pulse_req();
    chk("R9 rd0", rd_a[0], 20'h00000);
    chk("R9 rd1 wrapped", rd_a[1], 20'hFFFFF);
    chk("R5 wdata1", wr_d[1], 8'hA5);
    chk("R4 wr port", wr_a[1], 20'h00012);
    chk("R8 done", n_done, 1);
  endtask

  task automatic t_mode_in();
    clear_log();
    io_src = 8'h3C;
    load(2'b10, 20'hFFFFF, 16'h0007, 16'd2);
    pulse_req();
    pulse_req();
    chk("R3 rd port", rd_a[0], 20'h00007);
    chk("R3 rd io", rd_i[0], 1);
    chk("R3 wr0", wr_a[0], 20'hFFFFF);
    chk("R9 wr1 wrapped", wr_a[1], 20'h00000);
    chk("R3 wr mem", wr_i[1], 0);
    chk("R5 wdata", wr_d[1], 8'h3C);
    clear_log();
    io_src = 8'hC1;
    load(2'b11, 20'h00200, 16'h0009, 16'd2);
    pulse_req();
    pulse_req();
    chk("R3 down wr0", wr_a[0], 20'h00200);
    chk("R3 down wr1", wr_a[1], 20'h001FF);
    chk("R4 rd port", rd_a[1], 20'h00009);
    chk("R5 wdata", wr_d[0], 8'hC1);
  endtask

  task automatic t_level();
    clear_log();
    load(2'b00, 20'h00300, 16'h0001, 16'd4);
    @(negedge clk); req_in = 1'b1;
    repeat (40) @(negedge clk);
    req_in = 1'b0;
    repeat (12) @(negedge clk);
    chk("R6 level moves one byte", n_wr, 1);
    chk("R6 still armed", chan_en, 1);
  endtask

  task automatic t_pending();
    clear_log();
    load(2'b00, 20'h00400, 16'h0002, 16'd5);
    @(negedge clk); req_in = 1'b1;
    repeat (3) @(negedge clk);
    req_in = 1'b0;
    @(negedge clk);
    chk("R7 in flight", bus_rd, 1);
    req_in = 1'b1;
    repeat (3) @(negedge clk);
    req_in = 1'b0;
    repeat (20) @(negedge clk);
    chk("R7 two bytes", n_wr, 2);
    chk("R7 second addr", rd_a[1], 20'h00401);
    chk("R7 armed", chan_en, 1);
  endtask

  task automatic t_disabled();
    clear_log();
    load(2'b00, 20'h00000, 16'h0000, 16'd0);
    chk("R11 count 0 stays off", chan_en, 0);
    pulse_req();
    chk("R10 no read while off", n_rd, 0);
    chk("R10 no write while off", n_wr, 0);
  endtask

  task automatic t_busy_load();
    clear_log();
    load(2'b00, 20'h00500, 16'h0003, 16'd3);
    @(negedge clk); req_in = 1'b1;
    repeat (4) @(negedge clk);
    req_in = 1'b0;
    cfg_mode = 2'b11; cfg_count = 16'd0; cfg_load = 1'b1;
    @(negedge clk);
    cfg_load = 1'b0;
    repeat (12) @(negedge clk);
    chk("R11 mode kept", cur_mode, 2'b00);
    chk("R11 still armed", chan_en, 1);
    chk("R11 byte moved", wr_a[0], 20'h00003);
    load(2'b10, 20'h00000, 16'h0000, 16'd0);
    chk("R11 mode stored", cur_mode, 2'b10);
    chk("R11 zero count off", chan_en, 0);
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset();
    t_mode_up_out();
    t_disabled();
    t_mode_down_out();
    t_mode_in();
    t_level();
    t_pending();
    t_busy_load();
    report();
  end
endmodule